// File: doc/BRIEF.md
# USB Event Interrupt Aggregator

This block collects single-cycle event pulses from a USB device-and-hub engine and turns them into two processor interrupt requests. The first group covers transfer and frame events: the three function endpoints, the hub control endpoint, the late end-of-frame point and start of frame. These events are held in a sticky event status register. A mask register blocks each of them individually, and firmware clears them by writing ones to a separate acknowledge register. The second group covers bus power events: global suspend, resume and remote wakeup. These are held in a power status register, gated by an enable register, and cleared by writing ones to the status bits themselves.

On each start-of-frame pulse the block also captures the current frame number. Firmware reads it back as a low byte and a high byte. Every register sits in a small map selected by a 3-bit address. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`.

Top module: `usb_evt_irq`

## Requirements
- R1: After a synchronous active-low reset, both status registers, the power enable register and the frame number read zero, the event mask reads 0x3F (all sources blocked), and both request outputs are low.
- R2: An event pulse sets its bit in the event status register (address 0). The bit positions are: bit 0 function endpoint 0, bit 1 function endpoint 1, bit 2 function endpoint 2, bit 3 hub endpoint 0, bit 4 late end-of-frame, bit 5 start of frame. The bit stays set until it is cleared.
- R3: Writing a 1 to a bit of the acknowledge register (address 2) clears the matching event status bit. Bits written as 0 leave their status unchanged, and writes to address 0 have no effect on the status.
- R4: The acknowledge register is write-only and reads as zero.
- R5: Power status (address 3) holds suspend in bit 0, resume in bit 1 and remote wakeup in bit 2. Writing a 1 to one of these bits clears it, and writing a 0 leaves it unchanged.
- R6: When an event pulse and a clear for the same bit land in the same cycle, the bit ends up set. This holds for both status registers.
- R7: `irq_ev` is high one cycle after any event status bit is set while its bit in the event mask (address 1) is 0. A mask bit of 1 blocks that source.
- R8: `irq_pwr` is high one cycle after any power status bit is set while its bit in the power enable register (address 4) is 1.
- R9: A start-of-frame pulse captures `frame_in`. Bits 7:0 read back at address 5 and the remaining high bits at address 6. The captured value holds until the next start-of-frame pulse.
- R10: A request output falls one cycle after its last unblocked source is cleared, masked or disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_pulse | input | 6 | Transfer and frame event pulses, bit order as in R2 |
| pwr_pulse | input | 3 | Suspend, resume, remote wakeup pulses (bits 0..2) |
| frame_in | input | FRAME_W | Frame number from the serial engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| irq_ev | output | 1 | Request line for transfer and frame events |
| irq_pwr | output | 1 | Request line for power events |

## Verification
A new event pulse and a firmware clear of the same status bit can fall on the same clock edge. This can happen on the acknowledge path and on the write-one-to-clear power path. The bench drives a pulse and the clearing write in one cycle on both paths. It then judges the result by reading the status back: the bit must still be set and the request line must stay high. In the same step, a bit cleared without a competing pulse must read as zero, which shows the clear itself was not suppressed.

// File: rtl/usbirq_pkg.sv
// Package: shared counts, bit positions and register addresses of the
// USB event interrupt aggregator. Assumes a 3-bit register address.
package usbirq_pkg;
    localparam int NUM_EV  = 6;
    localparam int NUM_PWR = 3;
    localparam int REG_AW  = 3;

    // event status bit positions (firmware decodes these)
    localparam int EV_FEP0 = 0;
    localparam int EV_FEP1 = 1;
    localparam int EV_FEP2 = 2;
    localparam int EV_HEP0 = 3;
    localparam int EV_EOF2 = 4;
    localparam int EV_SOF  = 5;

    // power status bit positions
    localparam int PW_SUSP  = 0;
    localparam int PW_RSM   = 1;
    localparam int PW_RWAKE = 2;

    // register addresses
    localparam logic [REG_AW-1:0] SEL_EVSTAT = 3'd0;
    localparam logic [REG_AW-1:0] SEL_EVMASK = 3'd1;
    localparam logic [REG_AW-1:0] SEL_EVACK  = 3'd2;
    localparam logic [REG_AW-1:0] SEL_PWSTAT = 3'd3;
    localparam logic [REG_AW-1:0] SEL_PWEN   = 3'd4;
    localparam logic [REG_AW-1:0] SEL_FRLO   = 3'd5;
    localparam logic [REG_AW-1:0] SEL_FRHI   = 3'd6;
endpackage

// File: rtl/usbirq_sticky.sv
// Sticky status bank: each bit is set by a pulse and cleared by a strobe.
// A set and a clear in the same cycle leave the bit set.
// Assumes pulses and strobes are synchronous to clk.
module usbirq_sticky #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // hold bits; set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= set_i | (q & ~clr_i);
        end
    end

    assign q_o = q;
endmodule

// File: rtl/usbirq_ctlreg.sv
// Plain control register with a parameter reset value, loaded by a write strobe.
// Assumes d_i is valid in the cycle we_i is high.
module usbirq_ctlreg #(
    parameter int         W   = 6,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // load on write, reset to RST
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST;
        end else if (we_i) begin
            q <= d_i;
        end
    end

    assign q_o = q;
endmodule

// File: rtl/usbirq_gate.sv
// Request gate: ORs latched sources passed by a per-bit control and registers
// the result. CTL_BLOCKS selects polarity: 1 means a set control bit blocks the
// source (mask), 0 means a set control bit passes it (enable).
module usbirq_gate #(
    parameter int W          = 6,
    parameter bit CTL_BLOCKS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] ctl_i,
    output logic         irq_o
);
    logic [W-1:0] pass;
    logic         irq_q;

    generate
        if (CTL_BLOCKS) begin : g_mask
            assign pass = stat_i & ~ctl_i;
        end else begin : g_enable
            assign pass = stat_i & ctl_i;
        end
    endgenerate

    // register the OR of passed sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pass;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/usbirq_frame.sv
// Frame number capture: loads frame_i on each start-of-frame strobe.
// Assumes frame_i is stable in the strobe cycle.
module usbirq_frame #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [FRAME_W-1:0] fr_q;

    // capture on start of frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q <= '0;
        end else if (cap_i) begin
            fr_q <= frame_i;
        end
    end

    assign frame_o = fr_q;
endmodule

// File: rtl/usbirq_regif.sv
// Register interface: decodes writes into load and clear strobes and
// multiplexes read data. The acknowledge address returns zero.
// Assumes DATA_W >= NUM_EV and FRAME_W > DATA_W.
module usbirq_regif
    import usbirq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 11
) (
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EV-1:0]  ev_stat,
    input  logic [NUM_EV-1:0]  ev_mask,
    input  logic [NUM_PWR-1:0] pwr_stat,
    input  logic [NUM_PWR-1:0] pwr_en,
    input  logic [FRAME_W-1:0] frame,
    output logic               mask_we,
    output logic               en_we,
    output logic [NUM_EV-1:0]  ack_clr,
    output logic [NUM_PWR-1:0] pwr_clr,
    output logic [DATA_W-1:0]  rdata
);
    localparam int HI_W = FRAME_W - DATA_W;

    logic unused_wd;
    assign unused_wd = ^wdata[DATA_W-1:NUM_EV];

    // write decode into strobes
    always_comb begin
        mask_we = wr_en && (addr == SEL_EVMASK);
        en_we   = wr_en && (addr == SEL_PWEN);
        ack_clr = (wr_en && (addr == SEL_EVACK))  ? wdata[NUM_EV-1:0]  : '0;
        pwr_clr = (wr_en && (addr == SEL_PWSTAT)) ? wdata[NUM_PWR-1:0] : '0;
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            SEL_EVSTAT: rdata[NUM_EV-1:0]  = ev_stat;
            SEL_EVMASK: rdata[NUM_EV-1:0]  = ev_mask;
            SEL_PWSTAT: rdata[NUM_PWR-1:0] = pwr_stat;
            SEL_PWEN:   rdata[NUM_PWR-1:0] = pwr_en;
            SEL_FRLO:   rdata              = frame[DATA_W-1:0];
            SEL_FRHI:   rdata[HI_W-1:0]    = frame[FRAME_W-1:DATA_W];
            default:    rdata              = '0;
        endcase
    end
endmodule

// File: rtl/usb_evt_irq.sv
// Top: USB event interrupt aggregator. Latches transfer/frame and power
// events, gates them by mask (1 blocks) and enable (1 passes), drives two
// registered requests and captures the frame number on start of frame.
// Assumes all inputs synchronous to clk; reset is synchronous active-low.
module usb_evt_irq
    import usbirq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EV-1:0]  ev_pulse,
    input  logic [NUM_PWR-1:0] pwr_pulse,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_ev,
    output logic               irq_pwr
);
    logic [NUM_EV-1:0]  ev_stat_q, ev_mask_q, ack_clr;
    logic [NUM_PWR-1:0] pwr_stat_q, pwr_en_q, pwr_clr;
    logic [FRAME_W-1:0] frame_q;
    logic               mask_we, en_we;

    usbirq_regif #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_regif (
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ev_stat(ev_stat_q), .ev_mask(ev_mask_q),
        .pwr_stat(pwr_stat_q), .pwr_en(pwr_en_q), .frame(frame_q),
        .mask_we(mask_we), .en_we(en_we),
        .ack_clr(ack_clr), .pwr_clr(pwr_clr), .rdata(rdata)
    );

    usbirq_sticky #(.W(NUM_EV)) u_ev_stat (
        .clk(clk), .rst_n(rst_n), .set_i(ev_pulse), .clr_i(ack_clr), .q_o(ev_stat_q)
    );

    usbirq_sticky #(.W(NUM_PWR)) u_pwr_stat (
        .clk(clk), .rst_n(rst_n), .set_i(pwr_pulse), .clr_i(pwr_clr), .q_o(pwr_stat_q)
    );

    usbirq_ctlreg #(.W(NUM_EV), .RST({NUM_EV{1'b1}})) u_ev_mask (
        .clk(clk), .rst_n(rst_n), .we_i(mask_we), .d_i(wdata[NUM_EV-1:0]), .q_o(ev_mask_q)
    );

    usbirq_ctlreg #(.W(NUM_PWR), .RST('0)) u_pwr_en (
        .clk(clk), .rst_n(rst_n), .we_i(en_we), .d_i(wdata[NUM_PWR-1:0]), .q_o(pwr_en_q)
    );

    usbirq_gate #(.W(NUM_EV), .CTL_BLOCKS(1'b1)) u_gate_ev (
        .clk(clk), .rst_n(rst_n), .stat_i(ev_stat_q), .ctl_i(ev_mask_q), .irq_o(irq_ev)
    );

    usbirq_gate #(.W(NUM_PWR), .CTL_BLOCKS(1'b0)) u_gate_pwr (
        .clk(clk), .rst_n(rst_n), .stat_i(pwr_stat_q), .ctl_i(pwr_en_q), .irq_o(irq_pwr)
    );

    usbirq_frame #(.FRAME_W(FRAME_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cap_i(ev_pulse[EV_SOF]), .frame_i(frame_in), .frame_o(frame_q)
    );
endmodule

// File: rtl/usbirq_chk.sv
// Checker for usb_evt_irq: relates pulses, clear strobes, status, controls
// and request outputs across cycles. Attached by bind below.
module usbirq_chk
    import usbirq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EV-1:0]  ev_pulse,
    input logic [NUM_PWR-1:0] pwr_pulse,
    input logic [NUM_EV-1:0]  ev_stat,
    input logic [NUM_EV-1:0]  ev_mask,
    input logic [NUM_PWR-1:0] pwr_stat,
    input logic [NUM_PWR-1:0] pwr_en,
    input logic [NUM_EV-1:0]  ack_clr,
    input logic [NUM_PWR-1:0] pwr_clr,
    input logic [FRAME_W-1:0] frame_in,
    input logic [FRAME_W-1:0] frame_q,
    input logic [REG_AW-1:0]  addr,
    input logic [DATA_W-1:0]  rdata,
    input logic               irq_ev,
    input logic               irq_pwr
);
    AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (ev_stat == '0 && pwr_stat == '0 && !irq_ev && !irq_pwr)); // R1

    AST_EV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse != '0) |=> ((ev_stat & $past(ev_pulse)) == $past(ev_pulse))); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_clr & ~ev_pulse) != '0) |=> ((ev_stat & $past(ack_clr & ~ev_pulse)) == '0)); // R3

    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == SEL_EVACK) |-> (rdata == '0)); // R4

    AST_PWR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_clr & ~pwr_pulse) != '0) |=> ((pwr_stat & $past(pwr_clr & ~pwr_pulse)) == '0)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_pulse & ack_clr) != '0) |=> ((ev_stat & $past(ev_pulse & ack_clr)) == $past(ev_pulse & ack_clr))); // R6

    AST_EV_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_ev == $past((ev_stat & ~ev_mask) != '0))); // R7

    AST_PWR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_pwr == $past((pwr_stat & pwr_en) != '0))); // R8

    AST_FRAME_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse[EV_SOF] |=> (frame_q == $past(frame_in))); // R9

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_pulse[EV_SOF] |=> $stable(frame_q)); // R9
endmodule

bind usb_evt_irq usbirq_chk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .pwr_pulse(pwr_pulse),
    .ev_stat(ev_stat_q), .ev_mask(ev_mask_q), .pwr_stat(pwr_stat_q), .pwr_en(pwr_en_q),
    .ack_clr(ack_clr), .pwr_clr(pwr_clr), .frame_in(frame_in), .frame_q(frame_q),
    .addr(addr), .rdata(rdata), .irq_ev(irq_ev), .irq_pwr(irq_pwr)
);

// File: tb/tb_usb_evt_irq.sv
module tb_usb_evt_irq;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 11;
    localparam int NVEC    = 21;

    // vector: ev[33:28] pw[27:25] wr[24] waddr[23:21] wdata[20:13]
    //         chk_addr[12:10] exp_rdata[9:2] exp_irq_ev[1] exp_irq_pwr[0]
    localparam logic [33:0] VEC [NVEC] = '{
        {6'b000001, 3'b000, 1'b0, 3'd0, 8'h00, 3'd0, 8'h01, 1'b0, 1'b0}, // 0  R2 set, masked
        {6'b000000, 3'b000, 1'b1, 3'd1, 8'h3E, 3'd1, 8'h3E, 1'b1, 1'b0}, // 1  R7 unmask
        {6'b000000, 3'b000, 1'b1, 3'd0, 8'hFF, 3'd0, 8'h01, 1'b1, 1'b0}, // 2  R3 status write ignored
        {6'b000000, 3'b000, 1'b1, 3'd2, 8'h02, 3'd0, 8'h01, 1'b1, 1'b0}, // 3  R3 other bit ack
        {6'b000000, 3'b000, 1'b1, 3'd2, 8'h01, 3'd0, 8'h00, 1'b0, 1'b0}, // 4  R10 ack clears
        {6'b001000, 3'b000, 1'b1, 3'd1, 8'h37, 3'd0, 8'h08, 1'b1, 1'b0}, // 5  R2 hub ep0
        {6'b001000, 3'b000, 1'b1, 3'd2, 8'h08, 3'd0, 8'h08, 1'b1, 1'b0}, // 6  R6 set wins
        {6'b000000, 3'b000, 1'b1, 3'd1, 8'h3F, 3'd0, 8'h08, 1'b0, 1'b0}, // 7  R10 masked off
        {6'b000000, 3'b000, 1'b1, 3'd2, 8'h3F, 3'd2, 8'h00, 1'b0, 1'b0}, // 8  R4 ack reads 0
        {6'b000000, 3'b000, 1'b0, 3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0}, // 9  R3 cleared
        {6'b110110, 3'b000, 1'b0, 3'd0, 8'h00, 3'd0, 8'h36, 1'b0, 1'b0}, // 10 R2 multi
        {6'b000000, 3'b000, 1'b1, 3'd1, 8'h00, 3'd0, 8'h36, 1'b1, 1'b0}, // 11 R7
        {6'b000000, 3'b000, 1'b1, 3'd2, 8'h36, 3'd0, 8'h00, 1'b0, 1'b0}, // 12 R3
        {6'b000000, 3'b001, 1'b0, 3'd0, 8'h00, 3'd3, 8'h01, 1'b0, 1'b0}, // 13 R8 disabled
        {6'b000000, 3'b000, 1'b1, 3'd4, 8'h01, 3'd4, 8'h01, 1'b0, 1'b1}, // 14 R8 enable
        {6'b000000, 3'b000, 1'b1, 3'd3, 8'h00, 3'd3, 8'h01, 1'b0, 1'b1}, // 15 R5 zero write
        {6'b000000, 3'b000, 1'b1, 3'd3, 8'h01, 3'd3, 8'h00, 1'b0, 1'b0}, // 16 R5 w1c
        {6'b000000, 3'b110, 1'b0, 3'd0, 8'h00, 3'd3, 8'h06, 1'b0, 1'b0}, // 17 R8 not enabled
        {6'b000000, 3'b000, 1'b1, 3'd4, 8'h07, 3'd3, 8'h06, 1'b0, 1'b1}, // 18 R8
        {6'b000000, 3'b010, 1'b1, 3'd3, 8'h06, 3'd3, 8'h02, 1'b0, 1'b1}, // 19 R6 power set wins
        {6'b000000, 3'b000, 1'b1, 3'd3, 8'h02, 3'd3, 8'h00, 1'b0, 1'b0}  // 20 R10 power
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [5:0]         ev_pulse = '0;
    logic [2:0]         pwr_pulse = '0;
    logic [FRAME_W-1:0] frame_in = '0;
    logic               wr_en = 1'b0;
    logic [2:0]         addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic               irq_ev, irq_pwr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    usb_evt_irq #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .pwr_pulse(pwr_pulse),
        .frame_in(frame_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_ev(irq_ev), .irq_pwr(irq_pwr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string vec_req(input int i);
        case (i)
            0, 5, 10:        return "R2";
            2, 3, 9, 12:     return "R3";
            8:               return "R4";
            15, 16:          return "R5";
            6, 19:           return "R6";
            1, 11:           return "R7";
            13, 14, 17, 18:  return "R8";
            default:         return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // read one register at a quiet negedge
    task automatic read_reg(input logic [2:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic run_vec(input logic [33:0] v, input int i);
        @(negedge clk);
        ev_pulse = v[33:28]; pwr_pulse = v[27:25]; wr_en = v[24];
        addr = v[23:21]; wdata = v[20:13];
        @(negedge clk);
        ev_pulse = '0; pwr_pulse = '0; wr_en = 1'b0; addr = v[12:10];
        @(posedge clk);
        #1;
        check(vec_req(i), $sformatf("vec %0d rdata", i), int'(rdata), int'(v[9:2]));
        check(vec_req(i), $sformatf("vec %0d irq_ev", i), int'(irq_ev), int'(v[1]));
        check(vec_req(i), $sformatf("vec %0d irq_pwr", i), int'(irq_pwr), int'(v[0]));
    endtask

    task automatic check_reset_state(input string tag);
        logic [DATA_W-1:0] d;
        read_reg(3'd0, d); check("R1", {tag, " evstat"}, int'(d), 0);
        read_reg(3'd1, d); check("R1", {tag, " evmask"}, int'(d), 'h3F);
        read_reg(3'd3, d); check("R1", {tag, " pwstat"}, int'(d), 0);
        read_reg(3'd4, d); check("R1", {tag, " pwen"},   int'(d), 0);
        read_reg(3'd5, d); check("R1", {tag, " frlo"},   int'(d), 0);
        read_reg(3'd6, d); check("R1", {tag, " frhi"},   int'(d), 0);
        check("R1", {tag, " irq_ev"},  int'(irq_ev), 0);
        check("R1", {tag, " irq_pwr"}, int'(irq_pwr), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        logic [DATA_W-1:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state("initial reset");

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i], i);
        end

        // R9: frame capture on start of frame, hold otherwise
        @(negedge clk);
        frame_in = 11'h5A3;
        ev_pulse = 6'b100000;
        @(negedge clk);
        ev_pulse = '0;
        frame_in = 11'h123;
        read_reg(3'd5, d); check("R9", "frame low", int'(d), 'hA3);
        read_reg(3'd6, d); check("R9", "frame high", int'(d), 'h05);
        read_reg(3'd0, d); check("R2", "sof status bit", int'(d), 'h20);
        repeat (2) @(negedge clk);
        read_reg(3'd5, d); check("R9", "frame low held", int'(d), 'hA3);
        check("R7", "sof unmasked raises irq_ev", int'(irq_ev), 1);

        // R1: reset in mid-run with state set
        @(negedge clk);
        pwr_pulse = 3'b111;
        wr_en = 1'b1; addr = 3'd4; wdata = 8'h07;
        @(negedge clk);
        pwr_pulse = '0; wr_en = 1'b0;
        @(negedge clk);
        check("R8", "power irq before reset", int'(irq_pwr), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state("mid-run reset");

        report();
    end
endmodule